// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block lays a single pointer image over a pixel stream that already carries mixed video and graphics. A host write port fills a 1024-entry store of 2-bit colour codes, four palette words, a shape code and the X/Y location of the cursor's top-left corner. The raster arrives as a pixel-valid flag with horizontal and vertical pixel counters, together with the underlying YUV pixel. When the current raster position falls inside the cursor rectangle, the block fetches the stored code, looks up its palette word, widens the reduced-precision colour to 8 bits per component and blends it over the underlying pixel with one of four mix weights.

The same 1024-entry store can be viewed as one of five rectangles whose width grows as its height shrinks. Location and shape writes are held pending and only take effect at the start of vertical blanking. This keeps a frame from being drawn with half the old and half the new cursor. The cursor can sit anywhere on the screen. The parts that fall beyond the right or bottom end of the counter range are simply not drawn, and they never wrap around. Every pixel leaves the block exactly two clocks after it entered.

Top module: `cursorOverlay`

## Requirements
- R1: After reset, outValid and outYuv are 0, every palette word is 0 (mix weight 0) and the active shape code and location are 0, so valid pixels pass through unchanged.
- R2: outValid equals pixValid from two clocks earlier, and outYuv equals the pixel presented two clocks earlier whenever that pixel was not valid or lay outside the cursor.
- R3: The shape code c selects a width of 8<<c and a height of 128>>c pixels. Written shape values 5 to 7 are treated as 4.
- R4: Inside the rectangle, the code used for column dx and row dy (relative to the top-left corner) is the one stored at index dy*width+dx.
- R5: A palette word holds Y in bits 15:10, U in bits 9:6, V in bits 5:2 and the mix weight in bits 1:0. Y widens to {Y6,Y6[5:4]}, and U and V widen to {C4,C4}.
- R6: Per component, with underlying value a and cursor value c, weight 0 gives a, weight 1 gives floor((3a+c)/4), weight 2 gives floor((a+c)/2) and weight 3 gives c.
- R7: The rectangle spans X..X+width-1 and Y..Y+height-1 in counter units. Columns or rows that would lie past the counter maximum are dropped and never appear at small counter values.
- R8: Location and shape writes become active only on the clock edge at which vBlank is seen high after being low. Until then, the previous rectangle stays in use.
- R9: Host writes with wrEn high select a target by wrSel. A value of 0 loads the bitmap code wrData[1:0] at index wrAddr. A value of 1 loads palette word wrData[15:0] into entry wrAddr[1:0]. A value of 2 loads the shape from wrData[2:0]. A value of 3 loads X from wrData[10:0] and Y from wrData[21:11].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrSel | input | 2 | Host write target |
| wrAddr | input | 10 | Bitmap index or palette entry |
| wrData | input | 22 | Host write data |
| vBlank | input | 1 | Vertical blanking flag |
| pixValid | input | 1 | Incoming pixel is valid |
| hCount | input | 11 | Horizontal raster position |
| vCount | input | 11 | Vertical raster position |
| inYuv | input | 24 | Underlying pixel {Y,U,V} |
| outValid | output | 1 | Output pixel valid |
| outYuv | output | 24 | Blended pixel {Y,U,V} |

## Verification
The hardest situation to reach is a cursor that straddles the top of the counter range. Only that case shows whether the rectangle test wraps round to column or row 0. The bench places the cursor a few pixels short of the counter maximum in both directions and then probes both sides of the seam. A second awkward case is a location write that arrives mid-frame. The bench issues such a write without any blanking, probes the old rectangle to confirm that it is still drawn, and then raises vBlank and probes the new rectangle.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  typedef struct packed {
    logic [7:0] y;
    logic [7:0] u;
    logic [7:0] v;
  } yuv_t;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic bmpWr;
    logic palWr;
    logic hit;
  } strobe_t;

endpackage

// File: rtl/cursorCtrl.sv
module cursorCtrl
  import cursor_pkg::*;
#(
  parameter int COORD_W    = 11,
  parameter int ADDR_W     = 10,
  parameter int BASE_LOG   = 3,
  parameter int NUM_SHAPES = 5,
  parameter int SHAPE_W    = 3,
  parameter int DATA_W     = 22
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrSel,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               vBlank,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] hCount,
  input  logic [COORD_W-1:0] vCount,
  output strobe_t            strobes,
  output logic [ADDR_W-1:0]  readAddr,
  output logic [COORD_W-1:0] actX,
  output logic [COORD_W-1:0] actY,
  output logic [SHAPE_W-1:0] actShape
);

  localparam logic [SHAPE_W-1:0] MAX_SHAPE = SHAPE_W'(NUM_SHAPES - 1);
  localparam logic [COORD_W-1:0] BASE_SPAN = COORD_W'(1 << BASE_LOG);
  localparam logic [COORD_W-1:0] MAX_ROWS  = COORD_W'((1 << ADDR_W) >> BASE_LOG);

  logic [COORD_W-1:0] pendX, pendY;
  logic [SHAPE_W-1:0] pendShape;
  logic               prevVBlank;
  logic               frameEdge;

  assign frameEdge = vBlank && !prevVBlank;

  // pending registers written by host, copied at start of blanking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendX      <= '0;
      pendY      <= '0;
      pendShape  <= '0;
      prevVBlank <= 1'b0;
      actX       <= '0;
      actY       <= '0;
      actShape   <= '0;
    end else begin
      prevVBlank <= vBlank;
      if (wrEn && wrSel == 2'd2)
        pendShape <= (wrData[SHAPE_W-1:0] > MAX_SHAPE) ? MAX_SHAPE : wrData[SHAPE_W-1:0];
      if (wrEn && wrSel == 2'd3) begin
        pendX <= wrData[COORD_W-1:0];
        pendY <= wrData[2*COORD_W-1:COORD_W];
      end
      if (frameEdge) begin
        actX     <= pendX;
        actY     <= pendY;
        actShape <= pendShape;
      end
    end
  end

  // rectangle test on unsigned differences: a borrow means left/above
  logic [COORD_W:0]   dxW, dyW;
  logic [COORD_W-1:0] spanW, spanH;
  logic               inX, inY;
  logic [ADDR_W-1:0]  rowOff;

  always_comb begin
    dxW    = {1'b0, hCount} - {1'b0, actX};
    dyW    = {1'b0, vCount} - {1'b0, actY};
    spanW  = BASE_SPAN << actShape;
    spanH  = MAX_ROWS >> actShape;
    inX    = !dxW[COORD_W] && (dxW[COORD_W-1:0] < spanW);
    inY    = !dyW[COORD_W] && (dyW[COORD_W-1:0] < spanH);
    rowOff = ADDR_W'(dyW[COORD_W-1:0]) << (BASE_LOG + int'(actShape));
    readAddr = rowOff + ADDR_W'(dxW[COORD_W-1:0]);
  end

  assign strobes.bmpWr = wrEn && (wrSel == 2'd0);
  assign strobes.palWr = wrEn && (wrSel == 2'd1);
  assign strobes.hit   = pixValid && inX && inY;

endmodule

// File: rtl/cursorDatapath.sv
module cursorDatapath
  import cursor_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAL_W  = 16,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PAL_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] readAddr,
  input  logic              pixValid,
  input  yuv_t              inYuv,
  output logic              outValid,
  output yuv_t              outYuv
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAL_N = 1 << CODE_W;

  logic [CODE_W-1:0] bitmap [DEPTH];
  logic [PAL_W-1:0]  palette [PAL_N];

  logic [CODE_W-1:0] code1;
  logic              hit1, valid1;
  yuv_t              pix1;

  // bitmap store: synchronous write, synchronous read
  always_ff @(posedge clk) begin
    if (strobes.bmpWr) bitmap[wrAddr] <= wrData[CODE_W-1:0];
    code1 <= bitmap[readAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAL_N; i++) palette[i] <= '0;
    end else if (strobes.palWr) begin
      palette[wrAddr[CODE_W-1:0]] <= wrData;
    end
  end

  // stage 1: align underlying pixel with the bitmap read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit1   <= 1'b0;
      valid1 <= 1'b0;
      pix1   <= '0;
    end else begin
      hit1   <= strobes.hit;
      valid1 <= pixValid;
      pix1   <= inYuv;
    end
  end

  function automatic logic [7:0] mixComp(input logic [7:0] a, input logic [7:0] c,
                                         input logic [1:0] w);
    logic [9:0] s;
    s = '0;
    case (w)
      2'd0: mixComp = a;
      2'd1: begin
        s = ({2'b0, a} << 1) + {2'b0, a} + {2'b0, c};
        mixComp = s[9:2];
      end
      2'd2: begin
        s = {2'b0, a} + {2'b0, c};
        mixComp = s[8:1];
      end
      default: mixComp = c;
    endcase
  endfunction

  logic [PAL_W-1:0] entry;
  yuv_t             curCol, mixed;
  logic [1:0]       weight;

  always_comb begin
    entry    = palette[code1];
    curCol.y = {entry[15:10], entry[15:14]};
    curCol.u = {entry[9:6], entry[9:6]};
    curCol.v = {entry[5:2], entry[5:2]};
    weight   = entry[1:0];
    mixed.y  = mixComp(pix1.y, curCol.y, weight);
    mixed.u  = mixComp(pix1.u, curCol.u, weight);
    mixed.v  = mixComp(pix1.v, curCol.v, weight);
  end

  // stage 2: output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outYuv   <= '0;
    end else begin
      outValid <= valid1;
      outYuv   <= hit1 ? mixed : pix1;
    end
  end

endmodule

// File: rtl/cursorOverlay.sv
module cursorOverlay
  import cursor_pkg::*;
#(
  parameter int COORD_W    = 11,
  parameter int ADDR_W     = 10,
  parameter int BASE_LOG   = 3,
  parameter int NUM_SHAPES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [2*COORD_W-1:0] wrData,
  input  logic                 vBlank,
  input  logic                 pixValid,
  input  logic [COORD_W-1:0]   hCount,
  input  logic [COORD_W-1:0]   vCount,
  input  logic [23:0]          inYuv,
  output logic                 outValid,
  output logic [23:0]          outYuv
);

  localparam int DATA_W  = 2 * COORD_W;
  localparam int SHAPE_W = $clog2(NUM_SHAPES);
  localparam int PAL_W   = 16;

  strobe_t            strobes;
  logic [ADDR_W-1:0]  readAddr;
  logic [COORD_W-1:0] actX, actY;
  logic [SHAPE_W-1:0] actShape;
  yuv_t               outPix;

  cursorCtrl #(
    .COORD_W(COORD_W), .ADDR_W(ADDR_W), .BASE_LOG(BASE_LOG),
    .NUM_SHAPES(NUM_SHAPES), .SHAPE_W(SHAPE_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .vBlank(vBlank), .pixValid(pixValid), .hCount(hCount), .vCount(vCount),
    .strobes(strobes), .readAddr(readAddr),
    .actX(actX), .actY(actY), .actShape(actShape)
  );

  cursorDatapath #(.ADDR_W(ADDR_W), .PAL_W(PAL_W), .CODE_W(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr),
    .wrData(wrData[PAL_W-1:0]), .readAddr(readAddr), .pixValid(pixValid),
    .inYuv(yuv_t'(inYuv)), .outValid(outValid), .outYuv(outPix)
  );

  assign outYuv = outPix;

endmodule

// File: rtl/cursorOverlayChecker.sv
module cursorOverlayChecker #(
  parameter int COORD_W = 11,
  parameter int SHAPE_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic [23:0]        inYuv,
  input logic               outValid,
  input logic [23:0]        outYuv,
  input logic               vBlank,
  input logic [COORD_W-1:0] actX,
  input logic [COORD_W-1:0] actY,
  input logic [SHAPE_W-1:0] actShape
);

  // cycles since reset, saturating, so $past never reaches into reset
  logic [1:0] cyc;
  always_ff @(posedge clk) begin
    if (!rstN) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3) |-> (outValid == $past(pixValid, 2)));

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && !$past(pixValid, 2)) |-> (outYuv == $past(inYuv, 2)));

  assert_frame_update_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && ({actX, actY, actShape} != $past({actX, actY, actShape})))
      |-> ($past(vBlank) && !$past(vBlank, 2)));

  assert_shape_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    actShape <= SHAPE_W'(4));

endmodule

bind cursorOverlay cursorOverlayChecker #(.COORD_W(COORD_W), .SHAPE_W(SHAPE_W)) u_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .inYuv(inYuv),
  .outValid(outValid), .outYuv(outYuv), .vBlank(vBlank),
  .actX(actX), .actY(actY), .actShape(actShape)
);

// File: tb/tb_cursorOverlay.sv
module tb_cursorOverlay;

  localparam int CLK_PERIOD = 10;
  localparam int COORD_W = 11;
  localparam int ADDR_W  = 10;

  logic clk, rstN, wrEn, vBlank, pixValid;
  logic [1:0] wrSel;
  logic [ADDR_W-1:0] wrAddr;
  logic [2*COORD_W-1:0] wrData;
  logic [COORD_W-1:0] hCount, vCount;
  logic [23:0] inYuv, outYuv;
  logic outValid;

  cursorOverlay dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrAddr(wrAddr),
    .wrData(wrData), .vBlank(vBlank), .pixValid(pixValid), .hCount(hCount),
    .vCount(vCount), .inYuv(inYuv), .outValid(outValid), .outYuv(outYuv)
  );

  int nChecks = 0, nFails = 0;
  logic [1:0]  mBmp [1024];
  logic [15:0] mPal [4];
  int aX = 0, aY = 0, aS = 0, pX = 0, pY = 0, pS = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [23:0] underPix(int h, int v);
    return {8'(h * 3 + v), 8'(v * 5 + 17), 8'(h ^ 165)};
  endfunction

  function automatic logic [7:0] mixRef(logic [7:0] a, logic [7:0] c, logic [1:0] w);
    case (w)
      2'd0: return a;
      2'd1: return 8'((3 * int'(a) + int'(c)) / 4);
      2'd2: return 8'((int'(a) + int'(c)) / 2);
      default: return c;
    endcase
  endfunction

  function automatic logic [23:0] expPix(int h, int v, bit valid, logic [23:0] und);
    int w, ht, dx, dy;
    logic [15:0] e;
    logic [7:0] cy, cu, cv;
    w  = 8 << aS;
    ht = 128 >> aS;
    dx = h - aX;
    dy = v - aY;
    if (!valid || dx < 0 || dx >= w || dy < 0 || dy >= ht) return und;
    e  = mPal[mBmp[dy * w + dx]];
    cy = {e[15:10], e[15:14]};
    cu = {e[9:6], e[9:6]};
    cv = {e[5:2], e[5:2]};
    return {mixRef(und[23:16], cy, e[1:0]), mixRef(und[15:8], cu, e[1:0]),
            mixRef(und[7:0], cv, e[1:0])};
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic probe(string tag, int h, int v, bit valid);
    logic [23:0] u;
    u = underPix(h, v);
    @(negedge clk);
    pixValid = valid; hCount = COORD_W'(h); vCount = COORD_W'(v); inYuv = u;
    @(negedge clk);
    pixValid = 1'b0;
    @(posedge clk); #1;
    check({tag, " valid"}, 24'(outValid), 24'(valid));
    check({tag, " pixel"}, outYuv, expPix(h, v, valid, u));
  endtask

  task automatic hostWrite(logic [1:0] sel, int addr, logic [21:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrAddr = ADDR_W'(addr); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setPos(int x, int y);
    hostWrite(2'd3, 0, 22'((y << 11) | x));
    pX = x; pY = y;
  endtask

  task automatic setShape(int c);
    hostWrite(2'd2, 0, 22'(c));
    pS = (c > 4) ? 4 : c;
  endtask

  task automatic frameStart();
    @(negedge clk); vBlank = 1'b1;
    @(negedge clk); vBlank = 1'b0;
    aX = pX; aY = pY; aS = pS;
  endtask

  // R1: reset values at the ports
  task automatic tReset();
    @(posedge clk); #1;
    check("R1 outValid", 24'(outValid), 24'd0);
    check("R1 outYuv", outYuv, 24'd0);
    probe("R1 transparent at origin", 0, 0, 1'b1);
    probe("R1 transparent inside", 3, 7, 1'b1);
  endtask

  // R9: host write encodings for bitmap and palette
  task automatic tLoad();
    for (int i = 0; i < 1024; i++) begin
      mBmp[i] = 2'((i ^ (i >> 5)) & 3);
      @(negedge clk);
      wrEn = 1'b1; wrSel = 2'd0; wrAddr = ADDR_W'(i); wrData = 22'(mBmp[i]);
    end
    @(negedge clk); wrEn = 1'b0;
    mPal[0] = {6'h3F, 4'hF, 4'h0, 2'd0};
    mPal[1] = {6'h20, 4'h3, 4'hC, 2'd1};
    mPal[2] = {6'h05, 4'hA, 4'h5, 2'd2};
    mPal[3] = {6'h2A, 4'h1, 4'hE, 2'd3};
    for (int i = 0; i < 4; i++) hostWrite(2'd1, i, 22'(mPal[i]));
  endtask

  // R3 R4: each shape, corners and just outside
  task automatic tShapes();
    for (int s = 0; s < 5; s++) begin
      int x, y, w, h;
      x = 100 + s * 40; y = 50 + s * 10; w = 8 << s; h = 128 >> s;
      setShape(s); setPos(x, y); frameStart();
      probe("R3 R4 top-left", x, y, 1'b1);
      probe("R3 R4 top-right", x + w - 1, y, 1'b1);
      probe("R3 R4 bottom-left", x, y + h - 1, 1'b1);
      probe("R3 R4 bottom-right", x + w - 1, y + h - 1, 1'b1);
      probe("R3 R4 interior", x + 3, y + 5, 1'b1);
      probe("R3 right of box", x + w, y, 1'b1);
      probe("R3 below box", x, y + h, 1'b1);
      probe("R3 left of box", x - 1, y, 1'b1);
    end
    setShape(6); setPos(400, 300); frameStart();
    probe("R3 code 6 as 4 last column", 527, 300, 1'b1);
    probe("R3 code 6 as 4 past width", 528, 300, 1'b1);
    probe("R3 code 6 as 4 last row", 420, 307, 1'b1);
    probe("R3 code 6 as 4 past height", 420, 308, 1'b1);
  endtask

  // R5 R6 R9: all four mix weights on consecutive codes 0..3
  task automatic tMix();
    setShape(2); setPos(10, 20); frameStart();
    for (int k = 0; k < 4; k++) probe("R5 R6 R9 weight sweep", 10 + k, 20, 1'b1);
    for (int k = 32; k < 36; k++) probe("R5 R6 second row sweep", 10 + k - 32, 21, 1'b1);
  endtask

  // R8: location and shape held until vBlank rises
  task automatic tDefer();
    setPos(300, 200); setShape(0);
    probe("R8 old box still drawn", 11, 20, 1'b1);
    probe("R8 old box corner", 41, 51, 1'b1);
    probe("R8 new box not yet drawn", 301, 201, 1'b1);
    frameStart();
    probe("R8 new box drawn", 301, 201, 1'b1);
    probe("R8 old box gone", 11, 20, 1'b1);
  endtask

  // R7: near the counter maximum, no wrap in either direction
  task automatic tClip();
    setShape(2); setPos(2040, 2030); frameStart();
    probe("R7 last column inside", 2047, 2030, 1'b1);
    probe("R7 no wrap to column 0", 0, 2030, 1'b1);
    probe("R7 no wrap to column 5", 5, 2031, 1'b1);
    probe("R7 last row inside", 2041, 2047, 1'b1);
    probe("R7 no wrap to row 0", 2041, 0, 1'b1);
  endtask

  // R2: invalid pixels pass through, validity delayed by two
  task automatic tInvalid();
    setShape(2); setPos(10, 20); frameStart();
    probe("R2 invalid inside box", 13, 20, 1'b0);
    probe("R2 valid outside box", 600, 500, 1'b1);
    probe("R2 invalid outside box", 601, 500, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrAddr = '0; wrData = '0;
    vBlank = 1'b0; pixValid = 1'b0; hCount = '0; vCount = '0; inYuv = '0;
    for (int i = 0; i < 4; i++) mPal[i] = '0;
    for (int i = 0; i < 1024; i++) mBmp[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    tReset();
    tLoad();
    tShapes();
    tMix();
    tDefer();
    tClip();
    tInvalid();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule